// File: doc/BRIEF.md
# Rotating Register File

This block is a register file for a statically scheduled loop datapath. Each logical register specifier is split into one of two regions. A low region of fixed registers maps straight through to physical storage. A high region rotates: a base value is added to the specifier, wrapping inside that region, so the same instruction field reaches a different physical register on every loop iteration.

A loop-branch pulse steps the base down by one. A value written under specifier `s` in one iteration is therefore found under specifier `s+1` in the next. A scheduler can express a producer-to-consumer latency of `k` iterations as a distance of `k` between the two specifiers. The file has two combinational read ports and one write port. The write port commits on the clock edge.

Top module: `rot_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, the rotation base is zero and every one of the 16 registers reads as zero.
- R2: Specifiers 0 to 7 (the fixed region) address physical registers 0 to 7 directly, whatever the base.
- R3: Specifiers 8 to 15 (the rotating region) address physical register 8 + ((specifier − 8 + base) mod 8).
- R4: Each clock edge with `loop_br_i` high lowers the base by one. With `loop_br_i` low, the base holds.
- R5: Lowering the base from 0 gives 7, so eight pulses bring the base back to its start value.
- R6: Reads and writes in the same cycle as a loop-branch pulse use the base from before the pulse.
- R7: A write and a read to the same physical register in one cycle return the old value on the read. The new value appears from the next cycle.
- R8: With `wr_en_i` low, no register changes, whatever the write index and data.
- R9: The two read ports are independent: each returns the register its own specifier selects, in the same cycle.
- R10: A value written under rotating specifier `s` is read under specifier `s+k` after exactly `k` loop-branch pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the base and all registers |
| loop_br_i | input | 1 | Loop-branch pulse; lowers the base by one at the clock edge |
| rd_a_idx_i | input | 4 | Logical specifier for read port A |
| rd_a_data_o | output | 16 | Read port A data, combinational |
| rd_b_idx_i | input | 4 | Logical specifier for read port B |
| rd_b_data_o | output | 16 | Read port B data, combinational |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Logical specifier for the write port |
| wr_data_i | input | 16 | Write data |

## Verification
The assertions check every cycle that the base steps down by one on a pulse and holds otherwise, and that it wraps from zero to the top of the region. They also check that fixed specifiers pass through unchanged and that rotating specifiers stay inside the rotating region. Finally, they check that a committed write is present in storage on the next cycle.

Only the bench scenarios show the exact rotated address for a given base, and that a same-cycle read returns the old value. The bench also shows that accesses in a pulse cycle use the old base, that a disabled write leaves the register untouched, and that a value moves by one specifier per iteration over several pulses.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    // Default geometry of the rotating register file
    localparam int unsigned DEF_DATA_W   = 16;
    localparam int unsigned DEF_NONROT_N = 8;
    localparam int unsigned DEF_ROT_N    = 8;   // must be a power of two, >= 2

    // Identifiers for the three access ports that share the index mapping
    typedef enum logic [1:0] {
        PORT_RD_A = 2'd0,
        PORT_RD_B = 2'd1,
        PORT_WR   = 2'd2
    } port_sel_e;

    localparam int unsigned NUM_MAP_PORTS = 3;
endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl #(
    parameter int unsigned ROT_N = 8,
    localparam int unsigned ROT_W = $clog2(ROT_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [ROT_W-1:0] base_o
);
    typedef struct packed {
        logic [ROT_W-1:0] base;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            // modulo-ROT_N decrement: power-of-two width wraps 0 -> ROT_N-1
            st_d.base = st_q.base - ROT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = st_q.base;

    // R4: a pulse moves the base by exactly one step
    assert_base_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ($past(st_q.base) != '0 || !$past(step_i)) && st_q.base != '0)
            |=> (st_q.base == $past(st_q.base) - ROT_W'(1)));

    // R4: without a pulse the base holds
    assert_base_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(st_q.base));

    // R5: stepping from zero wraps to the top of the rotating region
    assert_base_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && st_q.base == '0) |=> (st_q.base == ROT_W'(ROT_N - 1)));
endmodule

// File: rtl/rrf_index_map.sv
module rrf_index_map #(
    parameter int unsigned NONROT_N = 8,
    parameter int unsigned ROT_N    = 8,
    localparam int unsigned NREG    = NONROT_N + ROT_N,
    localparam int unsigned IDX_W   = $clog2(NREG),
    localparam int unsigned ROT_W   = $clog2(ROT_N)
) (
    input  logic [IDX_W-1:0] logical_i,
    input  logic [ROT_W-1:0] base_i,
    output logic [IDX_W-1:0] phys_o
);
    logic [ROT_W-1:0] rel_off;
    logic [ROT_W-1:0] rot_off;

    always_comb begin
        // offset inside the rotating region, truncated to its width
        rel_off = ROT_W'(logical_i - IDX_W'(NONROT_N));
        rot_off = rel_off + base_i;
    end

    generate
        if (NONROT_N == 0) begin : g_all_rot
            assign phys_o = IDX_W'(rot_off);
        end else begin : g_split
            always_comb begin
                if (logical_i < IDX_W'(NONROT_N)) begin
                    phys_o = logical_i;
                end else begin
                    phys_o = IDX_W'(NONROT_N) + IDX_W'(rot_off);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NREG   = 16,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_phys_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_a_phys_i,
    input  logic [IDX_W-1:0]  rd_b_phys_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    output logic [DATA_W-1:0] rd_b_data_o
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.regs[wr_phys_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // reads see committed state only: no bypass of a same-cycle write
    assign rd_a_data_o = st_q.regs[rd_a_phys_i];
    assign rd_b_data_o = st_q.regs[rd_b_phys_i];

    // R7: a committed write is held in storage on the following cycle
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (st_q.regs[$past(wr_phys_i)] == $past(wr_data_i)));

    // R8: a cycle without a write leaves every register unchanged
    assert_no_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.regs));
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
    import rrf_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned NONROT_N = DEF_NONROT_N,
    parameter int unsigned ROT_N    = DEF_ROT_N,
    localparam int unsigned NREG    = NONROT_N + ROT_N,
    localparam int unsigned IDX_W   = $clog2(NREG),
    localparam int unsigned ROT_W   = $clog2(ROT_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_br_i,
    input  logic [IDX_W-1:0]  rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [IDX_W-1:0]  rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);
    logic [ROT_W-1:0] base;
    logic [IDX_W-1:0] logical_idx [NUM_MAP_PORTS];
    logic [IDX_W-1:0] phys_idx    [NUM_MAP_PORTS];

    rrf_base_ctrl #(.ROT_N(ROT_N)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (loop_br_i),
        .base_o (base)
    );

    assign logical_idx[PORT_RD_A] = rd_a_idx_i;
    assign logical_idx[PORT_RD_B] = rd_b_idx_i;
    assign logical_idx[PORT_WR]   = wr_idx_i;

    // every port sees the base as it stood before any pulse of this cycle
    generate
        for (genvar p = 0; p < NUM_MAP_PORTS; p++) begin : g_map
            rrf_index_map #(.NONROT_N(NONROT_N), .ROT_N(ROT_N)) u_map (
                .logical_i (logical_idx[p]),
                .base_i    (base),
                .phys_o    (phys_idx[p])
            );

            // R2: fixed specifiers pass straight through
            assert_fixed_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (logical_idx[p] < IDX_W'(NONROT_N)) |-> (phys_idx[p] == logical_idx[p]));

            // R3: rotating specifiers stay inside the rotating region
            assert_rot_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (logical_idx[p] >= IDX_W'(NONROT_N)) |-> (phys_idx[p] >= IDX_W'(NONROT_N)));
        end
    endgenerate

    rrf_storage #(.DATA_W(DATA_W), .NREG(NREG)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_phys_i   (phys_idx[PORT_WR]),
        .wr_data_i   (wr_data_i),
        .rd_a_phys_i (phys_idx[PORT_RD_A]),
        .rd_b_phys_i (phys_idx[PORT_RD_B]),
        .rd_a_data_o (rd_a_data_o),
        .rd_b_data_o (rd_b_data_o)
    );
endmodule

// File: tb/rot_regfile_bench.sv
module rot_regfile_bench;
    logic        clk;
    logic        rst_n;
    logic        loop_br_i;
    logic [3:0]  rd_a_idx_i;
    logic [15:0] rd_a_data_o;
    logic [3:0]  rd_b_idx_i;
    logic [15:0] rd_b_data_o;
    logic        wr_en_i;
    logic [3:0]  wr_idx_i;
    logic [15:0] wr_data_i;

    int n_checks = 0;
    int n_fails  = 0;

    rot_regfile u_rot_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_br_i   (loop_br_i),
        .rd_a_idx_i  (rd_a_idx_i),
        .rd_a_data_o (rd_a_data_o),
        .rd_b_idx_i  (rd_b_idx_i),
        .rd_b_data_o (rd_b_data_o),
        .wr_en_i     (wr_en_i),
        .wr_idx_i    (wr_idx_i),
        .wr_data_i   (wr_data_i)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    typedef struct packed {
        logic        br;
        logic        we;
        logic [3:0]  widx;
        logic [15:0] wdata;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [15:0] ea;
        logic [15:0] eb;
    } vec_t;

    // Rows run one per cycle from base 0; expected reads are before the edge.
    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        // R7: write spec 9 (phys 9), read same register -> old value 0
        '{1'b0, 1'b1, 4'd9,  16'h1111, 4'd9,  4'd3,  16'h0000, 16'h0000},
        // R7/R9: spec 9 now visible; spec 3 written this cycle still old
        '{1'b0, 1'b1, 4'd3,  16'h0333, 4'd9,  4'd3,  16'h1111, 16'h0000},
        // R6: pulse cycle; write spec 8 uses old base 0 -> phys 8
        '{1'b1, 1'b1, 4'd8,  16'h0888, 4'd9,  4'd3,  16'h1111, 16'h0333},
        // R3/R5: base 7; spec 10 -> phys 9, spec 9 -> phys 8
        '{1'b0, 1'b0, 4'd0,  16'h0000, 4'd10, 4'd9,  16'h1111, 16'h0888},
        // R8/R2: disabled write to spec 10 (phys 9); spec 15 -> phys 14; pulse
        '{1'b1, 1'b0, 4'd10, 16'hDEAD, 4'd3,  4'd15, 16'h0333, 16'h0000},
        // R4: base 6; spec 11 -> phys 9, spec 10 -> phys 8; write spec 15 -> phys 13
        '{1'b0, 1'b1, 4'd15, 16'h0F0F, 4'd11, 4'd10, 16'h1111, 16'h0888},
        // R3/R8: spec 15 -> phys 13; phys 9 untouched by disabled write
        '{1'b0, 1'b0, 4'd0,  16'h0000, 4'd15, 4'd11, 16'h0F0F, 16'h1111}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        loop_br_i  = 1'b0;
        wr_en_i    = 1'b0;
        wr_idx_i   = '0;
        wr_data_i  = '0;
        rd_a_idx_i = '0;
        rd_b_idx_i = '0;
    endtask

    // one cycle: drive after falling edge, sample reads, then cross rising edge
    task automatic cycle(input logic br, input logic we, input logic [3:0] widx,
                         input logic [15:0] wdata, input logic [3:0] ra, input logic [3:0] rb);
        @(negedge clk);
        loop_br_i  = br;
        wr_en_i    = we;
        wr_idx_i   = widx;
        wr_data_i  = wdata;
        rd_a_idx_i = ra;
        rd_b_idx_i = rb;
        #1;
    endtask

    task automatic read_pair(input logic [3:0] ra, input logic [3:0] rb);
        cycle(1'b0, 1'b0, 4'd0, 16'h0, ra, rb);
    endtask

    initial begin
        #(4 * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        // R1: all registers read zero during reset
        for (int i = 0; i < 8; i++) begin
            read_pair(4'(i), 4'(i + 8));
            check("R1", rd_a_data_o, 16'h0);
            check("R1", rd_b_data_o, 16'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            cycle(VECS[v].br, VECS[v].we, VECS[v].widx, VECS[v].wdata, VECS[v].ra, VECS[v].rb);
            check($sformatf("R9 row%0d port A", v), rd_a_data_o, VECS[v].ea);
            check($sformatf("R9 row%0d port B", v), rd_b_data_o, VECS[v].eb);
        end

        // base is 6 here; seven pulses give 5,4,3,2,1,0,7 (R5 wrap)
        for (int k = 0; k < 7; k++) cycle(1'b1, 1'b0, 4'd0, 16'h0, 4'd0, 4'd0);
        // R5: base 7, spec 14 -> 8 + (6+7) mod 8 = phys 13
        read_pair(4'd14, 4'd3);
        check("R5", rd_a_data_o, 16'h0F0F);
        // R2: fixed specifier unaffected by base 7
        check("R2", rd_b_data_o, 16'h0333);

        // R10: write spec 8 at base 7 (phys 15), three pulses -> base 4, spec 11 -> phys 15
        cycle(1'b0, 1'b1, 4'd8, 16'hAAAA, 4'd0, 4'd0);
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 4'd0, 16'h0, 4'd0, 4'd0);
        read_pair(4'd11, 4'd12);
        check("R10", rd_a_data_o, 16'hAAAA);
        // R3: spec 12 at base 4 -> phys 8 holds 0x0888
        check("R3", rd_b_data_o, 16'h0888);

        // R4: no pulse for a cycle, mapping unchanged
        read_pair(4'd11, 4'd12);
        check("R4", rd_a_data_o, 16'hAAAA);
        check("R4", rd_b_data_o, 16'h0888);

        // R1: reset mid-run clears registers and base
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        @(negedge clk);
        rst_n = 1'b1;
        read_pair(4'd11, 4'd13);
        check("R1", rd_a_data_o, 16'h0);
        check("R1", rd_b_data_o, 16'h0);
        // R1: base is zero after reset: write spec 9 lands in phys 9, read as spec 10 after one pulse
        cycle(1'b0, 1'b1, 4'd9, 16'h5555, 4'd0, 4'd0);
        cycle(1'b1, 1'b0, 4'd0, 16'h0, 4'd9, 4'd0);
        check("R1", rd_a_data_o, 16'h5555);
        read_pair(4'd10, 4'd9);
        check("R1", rd_a_data_o, 16'h5555);
        check("R1", rd_b_data_o, 16'h0);

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule